// File: doc/BRIEF.md
# Prioritized Pin-Function Multiplexer Port

This block controls an eight-pin general-purpose I/O port. Several peripheral signals compete for each pin. Every pin has a fixed priority chain over the enable bits of the peripherals that can reach it. The highest-priority peripheral whose enable is set takes the pin. When no peripheral on the chain is enabled, the pin falls back to GPIO. In GPIO mode a data register sets the output value and a direction register sets the output enable.

Pin ownership, pad output values and output enables are purely combinational from the enables, the peripheral signals and the two registers. A pin owned by a transmit function is driven. A pin owned by a receive function is released, and its pad value goes only to the peripheral that won it. A small register bus writes the two registers on the clock edge after the strobe. Reading the data register returns the stored bit for output pins and the live pad value for input pins.

Top module: `pinmux_port`

## Requirements
- R1: A synchronous active-high reset clears the data and direction registers to 0, so with no function enabled every pad output enable is 0.
- R2: A write with `bus_addr`=0 loads the data register and with `bus_addr`=1 loads the direction register. The new value is visible from the clock edge that samples `bus_wr`, not before.
- R3: A read with `bus_addr`=0 returns, per bit, the stored data bit where the direction bit is 1 and `pad_in` where it is 0.
- R4: A read with `bus_addr`=1 returns the direction register.
- R5: A pin with no enabled function on its chain drives `pad_out` from its data bit and `pad_oe` from its direction bit.
- R6: Pins 7 and 6 resolve CAN3 (`fn_en[3]`) over CAN4 here (`fn_en[4]`) over UART (`fn_en[8]`) over GPIO.
- R7: Pins 5 and 4 resolve CAN2 (`fn_en[2]`) over CAN0 here (`fn_en[6]`) over CAN4 here (`fn_en[5]`) over SPI (`fn_en[9]`) over GPIO.
- R8: Pins 3 and 2 resolve CAN1 (`fn_en[1]`) over CAN0 here (`fn_en[7]`) over SPI (`fn_en[9]`) over GPIO.
- R9: Pins 1 and 0 resolve CAN0 (`fn_en[0]`) over GPIO.
- R10: An odd pin owned by a CAN or UART function drives that function's transmit bit (`can_tx[ch]`, `uart_tx`) with enable 1. An even pin so owned has `pad_out`=0 and enable 0. An SPI-owned pin takes value and enable from `spi_do`/`spi_oe` at index 5 minus the pin number (0 clock, 1 MOSI, 2 select, 3 MISO).
- R11: `can_rx[ch]` follows the pad of the lowest-numbered even pin owned by CAN channel ch, `uart_rx` follows pad 6 when UART owns it, and `spi_di[k]` follows pad 5-k when SPI owns it. Every routed input not fed this way sits at 1.
- R12: The data register accepts writes while peripherals own the pins, and the written value appears on the pads once GPIO takes them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| fn_en | input | 10 | Peripheral enables, bit positions as in R6 to R9 |
| can_tx | input | 5 | CAN transmit bits, index is channel |
| can_rx | output | 5 | Routed CAN receive bits, index is channel |
| uart_tx | input | 1 | UART transmit bit |
| uart_rx | output | 1 | Routed UART receive bit |
| spi_do | input | 4 | SPI output values (clock, MOSI, select, MISO) |
| spi_oe | input | 4 | SPI output enables, same order |
| spi_di | output | 4 | Routed SPI input values, same order |
| pad_in | input | 8 | Buffered pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The assertions watch these on every cycle: the register load on a strobe, the bitwise read-back split by direction, GPIO fallback when nothing is enabled, and the top-priority function on each pin group, including the receive pin being released. Priority among the lower levels of a chain can only be shown by the bench's sweep of all 1024 enable patterns. The same holds for the receive routing when two routes of one channel are live at once, for SPI direction taken from the peripheral, and for a data write made while the pins are owned by peripherals.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int NPINS  = 8;
  localparam int NFN    = 10;
  localparam int NCAN   = 5;
  localparam int NSPI   = 4;
  localparam int NLEVEL = 4;
  localparam int CHW    = $clog2(NCAN);

  typedef enum logic [3:0] {
    FN_CAN0     = 4'd0,
    FN_CAN1     = 4'd1,
    FN_CAN2     = 4'd2,
    FN_CAN3     = 4'd3,
    FN_CAN4_HI  = 4'd4,
    FN_CAN4_MID = 4'd5,
    FN_CAN0_MID = 4'd6,
    FN_CAN0_LO  = 4'd7,
    FN_UART     = 4'd8,
    FN_SPI      = 4'd9,
    FN_GPIO     = 4'd10
  } fn_e;

  // Candidate at priority level lvl (0 = highest) for a pin.
  function automatic fn_e chain_at(input int pin, input int lvl);
    fn_e r;
    r = FN_GPIO;
    case (pin / 2)
      3: case (lvl)
           0: r = FN_CAN3;
           1: r = FN_CAN4_HI;
           2: r = FN_UART;
           default: r = FN_GPIO;
         endcase
      2: case (lvl)
           0: r = FN_CAN2;
           1: r = FN_CAN0_MID;
           2: r = FN_CAN4_MID;
           3: r = FN_SPI;
           default: r = FN_GPIO;
         endcase
      1: case (lvl)
           0: r = FN_CAN1;
           1: r = FN_CAN0_LO;
           2: r = FN_SPI;
           default: r = FN_GPIO;
         endcase
      default: case (lvl)
           0: r = FN_CAN0;
           default: r = FN_GPIO;
         endcase
    endcase
    return r;
  endfunction

  function automatic logic [CHW-1:0] chan_of(input fn_e f);
    case (f)
      FN_CAN1:                 return CHW'(1);
      FN_CAN2:                 return CHW'(2);
      FN_CAN3:                 return CHW'(3);
      FN_CAN4_HI, FN_CAN4_MID: return CHW'(4);
      default:                 return CHW'(0);
    endcase
  endfunction

  function automatic logic is_can(input fn_e f);
    return (f != FN_UART) && (f != FN_SPI) && (f != FN_GPIO);
  endfunction
endpackage

// File: rtl/pmx_regs.sv
module pmx_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         sel_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_en) begin
      if (sel_dir) dir_q  <= wdata;
      else         data_q <= wdata;
    end
  end

  always_comb begin
    if (sel_dir) rdata = dir_q;
    else         rdata = (dir_q & data_q) | (~dir_q & pad_in);
  end
endmodule

// File: rtl/pmx_arbiter.sv
module pmx_arbiter
  import pmx_pkg::*;
(
  input  logic [NFN-1:0] fn_en,
  output fn_e            owner [NPINS]
);
  always_comb begin
    fn_e cand;
    cand = FN_GPIO;
    for (int p = 0; p < NPINS; p++) begin
      owner[p] = FN_GPIO;
      // Walk from lowest to highest priority so the highest enabled wins.
      for (int l = NLEVEL - 1; l >= 0; l--) begin
        cand = chain_at(p, l);
        if (cand != FN_GPIO && fn_en[cand]) owner[p] = cand;
      end
    end
  end
endmodule

// File: rtl/pmx_pad_mux.sv
module pmx_pad_mux
  import pmx_pkg::*;
(
  input  fn_e              owner [NPINS],
  input  logic [NPINS-1:0] data_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NCAN-1:0]  can_tx,
  input  logic             uart_tx,
  input  logic [NSPI-1:0]  spi_do,
  input  logic [NSPI-1:0]  spi_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      pad_out[p] = 1'b0;
      pad_oe[p]  = 1'b0;
      case (owner[p])
        FN_GPIO: begin
          pad_out[p] = data_q[p];
          pad_oe[p]  = dir_q[p];
        end
        FN_SPI: begin
          if (p >= 2 && p <= 5) begin
            pad_out[p] = spi_do[2'(5 - p)];
            pad_oe[p]  = spi_oe[2'(5 - p)];
          end
        end
        FN_UART: begin
          if ((p % 2) == 1) begin
            pad_out[p] = uart_tx;
            pad_oe[p]  = 1'b1;
          end
        end
        default: begin
          if ((p % 2) == 1) begin
            pad_out[p] = can_tx[chan_of(owner[p])];
            pad_oe[p]  = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pmx_rx_route.sv
module pmx_rx_route
  import pmx_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  fn_e              owner [NPINS],
  input  logic [NPINS-1:0] pad_in,
  output logic [NCAN-1:0]  can_rx,
  output logic             uart_rx,
  output logic [NSPI-1:0]  spi_di
);
  always_comb begin
    can_rx  = {NCAN{IDLE}};
    uart_rx = IDLE;
    spi_di  = {NSPI{IDLE}};
    // Descending scan: a lower-numbered pin overrides a higher one.
    for (int p = NPINS - 1; p >= 0; p--) begin
      if ((p % 2) == 0) begin
        if (is_can(owner[p])) can_rx[chan_of(owner[p])] = pad_in[p];
        if (owner[p] == FN_UART) uart_rx = pad_in[p];
      end
      if (owner[p] == FN_SPI && p >= 2 && p <= 5) spi_di[2'(5 - p)] = pad_in[p];
    end
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NFN-1:0]   fn_en,
  input  logic [NCAN-1:0]  can_tx,
  output logic [NCAN-1:0]  can_rx,
  input  logic             uart_tx,
  output logic             uart_rx,
  input  logic [NSPI-1:0]  spi_do,
  input  logic [NSPI-1:0]  spi_oe,
  output logic [NSPI-1:0]  spi_di,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] dir_q;
  fn_e              owner [NPINS];

  pmx_regs #(.W(NPINS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .sel_dir(bus_addr),
    .wdata  (bus_wdata),
    .pad_in (pad_in),
    .data_q (data_q),
    .dir_q  (dir_q),
    .rdata  (bus_rdata)
  );

  pmx_arbiter u_arb (
    .fn_en(fn_en),
    .owner(owner)
  );

  pmx_pad_mux u_mux (
    .owner  (owner),
    .data_q (data_q),
    .dir_q  (dir_q),
    .can_tx (can_tx),
    .uart_tx(uart_tx),
    .spi_do (spi_do),
    .spi_oe (spi_oe),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
  );

  pmx_rx_route #(.IDLE(1'b1)) u_rx (
    .owner  (owner),
    .pad_in (pad_in),
    .can_rx (can_rx),
    .uart_rx(uart_rx),
    .spi_di (spi_di)
  );
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker
  import pmx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NFN-1:0]   fn_en,
  input logic [NCAN-1:0]  can_tx,
  input logic [NCAN-1:0]  can_rx,
  input logic             uart_rx,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] data_q,
  input logic [NPINS-1:0] dir_q
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (data_q == '0 && dir_q == '0));

  p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr) |=> dir_q == $past(bus_wdata));

  p_data_load_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |=> data_q == $past(bus_wdata));

  p_read_split_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_addr |-> ((((bus_rdata ^ pad_in) & ~dir_q) == '0) &&
                   (((bus_rdata ^ data_q) & dir_q) == '0)));

  p_gpio_fallback_r5: assert property (@(posedge clk) disable iff (rst)
    (fn_en == '0) |-> (pad_oe == dir_q && pad_out == data_q));

  p_top_hi_r6: assert property (@(posedge clk) disable iff (rst)
    fn_en[3] |-> (pad_oe[7] && !pad_oe[6] && pad_out[7] == can_tx[3]));

  p_top_mid_r7: assert property (@(posedge clk) disable iff (rst)
    fn_en[2] |-> (pad_oe[5] && !pad_oe[4] && pad_out[5] == can_tx[2]));

  p_top_lo_r8: assert property (@(posedge clk) disable iff (rst)
    fn_en[1] |-> (pad_oe[3] && !pad_oe[2] && pad_out[3] == can_tx[1]));

  p_can0_pins_r9: assert property (@(posedge clk) disable iff (rst)
    fn_en[0] |-> (pad_oe[1] && !pad_oe[0] && pad_out[1] == can_tx[0] &&
                  can_rx[0] == pad_in[0]));

  p_uart_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !fn_en[8] |-> uart_rx);
endmodule

bind pinmux_port pmx_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .fn_en    (fn_en),
  .can_tx   (can_tx),
  .can_rx   (can_rx),
  .uart_rx  (uart_rx),
  .pad_in   (pad_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .data_q   (data_q),
  .dir_q    (dir_q)
);

// File: tb/test_pinmux_port.sv
module test_pinmux_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [9:0] fn_en = '0;
  logic [4:0] can_tx = '1;
  logic [4:0] can_rx;
  logic       uart_tx = 1'b1;
  logic       uart_rx;
  logic [3:0] spi_do = '0;
  logic [3:0] spi_oe = '0;
  logic [3:0] spi_di;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] m_data, m_dir;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pinmux_port i_pinmux_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fn_en(fn_en),
    .can_tx(can_tx), .can_rx(can_rx), .uart_tx(uart_tx), .uart_rx(uart_rx),
    .spi_do(spi_do), .spi_oe(spi_oe), .spi_di(spi_di), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (fn_en=%0h)", tag, what, act, exp, fn_en);
    end
  endtask

  // Priority lists of function ids per pin pair, highest first.
  function automatic int model_owner(input int pin, input logic [9:0] en);
    int q[$];
    case (pin / 2)
      3: q = '{3, 4, 8};
      2: q = '{2, 6, 5, 9};
      1: q = '{1, 7, 9};
      default: q = '{0};
    endcase
    foreach (q[i]) if (en[q[i]]) return q[i];
    return -1;
  endfunction

  function automatic int chan(input int f);
    case (f)
      1: return 1;
      2: return 2;
      3: return 3;
      4, 5: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic check_all();
    logic [4:0] e_can;
    logic       e_uart;
    logic [3:0] e_spi;
    for (int p = 0; p < 8; p++) begin
      int o;
      logic ev, eo;
      string tag;
      o = model_owner(p, fn_en);
      tag = (p >= 6) ? "R6" : (p >= 4) ? "R7" : (p >= 2) ? "R8" : "R9";
      if (o < 0) begin
        ev = m_data[p]; eo = m_dir[p]; tag = "R5";
      end else if (o == 9) begin
        ev = spi_do[5 - p]; eo = spi_oe[5 - p];
      end else if (p % 2 == 1) begin
        ev = (o == 8) ? uart_tx : can_tx[chan(o)]; eo = 1'b1;
      end else begin
        ev = 1'b0; eo = 1'b0;
      end
      chk(tag, $sformatf("pad_out[%0d]", p), int'(pad_out[p]), int'(ev));
      chk(tag, $sformatf("pad_oe[%0d]", p), int'(pad_oe[p]), int'(eo));
    end
    e_can = '1; e_uart = 1'b1; e_spi = '1;
    for (int p = 6; p >= 0; p -= 2) begin
      int o;
      o = model_owner(p, fn_en);
      if (o >= 0 && o <= 7) e_can[chan(o)] = pad_in[p];
      if (o == 8) e_uart = pad_in[p];
    end
    for (int p = 2; p <= 5; p++)
      if (model_owner(p, fn_en) == 9) e_spi[5 - p] = pad_in[p];
    chk("R11", "can_rx", int'(can_rx), int'(e_can));
    chk("R11", "uart_rx", int'(uart_rx), int'(e_uart));
    chk("R11", "spi_di", int'(spi_di), int'(e_spi));
    if (bus_addr) chk("R4", "rdata", int'(bus_rdata), int'(m_dir));
    else chk("R3", "rdata", int'(bus_rdata), int'((m_data & m_dir) | (pad_in & ~m_dir)));
  endtask

  // Check current inputs, advance one clock, update the model, return at negedge.
  task automatic tick();
    #1;
    if (!rst) check_all();
    @(posedge clk);
    if (rst) begin
      m_data = '0; m_dir = '0;
    end else if (bus_wr) begin
      if (bus_addr) m_dir = bus_wdata;
      else m_data = bus_wdata;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;

    // R1: reset state
    bus_addr = 1'b1;
    #1;
    chk("R1", "dir after reset", int'(bus_rdata), 0);
    chk("R1", "pad_oe after reset", int'(pad_oe), 0);
    tick();

    // R2: direction write visible only after the edge
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hF0;
    #1;
    chk("R2", "dir before edge", int'(bus_rdata), 8'h00);
    tick();
    bus_wr = 1'b0;
    #1;
    chk("R2", "dir after edge", int'(bus_rdata), 8'hF0);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'hA5;
    tick();

    // R3: mixed direction read-back
    bus_wr = 1'b0; bus_addr = 1'b0; pad_in = 8'h3C;
    #1;
    chk("R3", "mixed readback", int'(bus_rdata), 8'hAC);
    tick();

    // R12: data write while every pin belongs to a peripheral
    fn_en = '1;
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h5A;
    tick();
    bus_addr = 1'b1; bus_wdata = 8'hFF;
    tick();
    bus_wr = 1'b0; fn_en = '0;
    #1;
    chk("R12", "pad_out after release", int'(pad_out), 8'h5A);
    tick();

    // R10: CAN transmit drive, SPI direction taken from the peripheral
    fn_en = 10'h008; can_tx = 5'b00000;
    #1;
    chk("R10", "pin7 value", int'(pad_out[7]), 0);
    chk("R10", "pin7 enable", int'(pad_oe[7]), 1);
    chk("R10", "pin6 enable", int'(pad_oe[6]), 0);
    tick();
    fn_en = 10'h200; spi_oe = 4'b0101; spi_do = 4'b0011;
    #1;
    chk("R10", "spi enables", int'(pad_oe[5:2]), 4'b1010);
    chk("R10", "spi values", int'(pad_out[5:2]), 4'b1100);
    tick();

    // Full sweep of enable patterns with random traffic (R5..R11, R3, R4)
    for (int e = 0; e < 1024; e++) begin
      fn_en     = 10'(e);
      can_tx    = 5'($urandom);
      uart_tx   = 1'($urandom);
      spi_do    = 4'($urandom);
      spi_oe    = 4'($urandom);
      pad_in    = 8'($urandom);
      bus_addr  = 1'($urandom);
      bus_wr    = ($urandom % 4) == 0;
      bus_wdata = 8'($urandom);
      tick();
    end
    bus_wr = 1'b0;
    tick();
    finish_run();
  end
endmodule